// File: doc/BRIEF.md
# Nibble Command Register Decoder

This block sits behind a byte-wide host link and turns a stream of command bytes into reads and writes on a small 8-bit register space with 8-bit addresses. Every command byte carries an opcode in bits 7:4 and a 4-bit payload in bits 3:0. Two opcodes fill the address one nibble at a time. A third opcode parks a low data nibble. A fourth supplies the high data nibble and commits the byte to the addressed register. The read opcodes return one byte upstream, and one of them also steps the address forward afterwards so that several registers can be fetched in a row.

Three registers live inside the block: a fixed identification value, a scratch register for link testing, and a mode/status register that starts and stops acquisition, enables memory readback and reports a trigger hit. All other addresses are passed to an external register port, where the memory controller and trigger logic attach.

Commands arrive on a valid/ready input. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. Read bytes leave on a valid/ready output. Once `rsp_valid` is high it stays high with `rsp_data` unchanged until a clock edge where `rsp_ready` is also high. While a read byte is waiting, command intake is stalled, so at most one byte is ever in flight.

Top module: `nib_reg_decoder`

## Requirements
- R1: After reset the address is 0x00, the staged data nibble is 0, the mode register reads 0x00, `acq_run` and `readback_en` are low, `rsp_valid` is low and `cmd_ready` is high.
- R2: Opcode 0x0 loads address bits 3:0 and opcode 0x1 loads address bits 7:4 from the payload, and each leaves the other nibble unchanged; `ext_addr` always shows the current address.
- R3: Opcode 0x2 only stages a data nibble. Opcode 0x3 writes {payload, staged nibble} to the addressed register on the edge that accepts it. The staged nibble is kept after the write.
- R4: A write leaves the address unchanged, so repeated data pairs after one address setup all go to the same register.
- R5: Opcode 0x4 places the addressed register's byte on `rsp_data` with `rsp_valid` high from the clock edge that accepts the command, and leaves the address unchanged.
- R6: Opcode 0x5 reads like 0x4 and then adds one to the address, wrapping from 0xFF to 0x00.
- R7: Address 0x00 always reads 0xA6, and writes to it have no effect.
- R8: Address 0x01 reads back the last byte written to it.
- R9: At address 0x02, writing 0x0D sets run and clears readback enable and the trigger flag; 0x11 clears run; 0x02 sets readback enable and clears run; any other value changes nothing. Reads return run in bit 0, readback enable in bit 1 and the trigger flag in bit 5. Run and readback enable drive `acq_run` and `readback_en`.
- R10: A `trig_hit` pulse while run is set makes the trigger flag sticky; it survives a stop; it is cleared only by a start write. A pulse while stopped is ignored.
- R11: Opcodes 0x6 to 0xF are accepted and cause no address change, no staged-nibble change, no write and no response.
- R12: `cmd_ready` is low whenever `rsp_valid` is high, and `rsp_data` holds steady until the byte is taken.
- R13: Addresses 0x03 to 0xFF go to the external port: a commit there pulses `ext_we` in the accepting cycle with `ext_addr`/`ext_wdata`, and a read there returns `ext_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Decoder can take a command |
| cmd_byte | input | 8 | Opcode in 7:4, payload in 3:0 |
| rsp_valid | output | 1 | Read byte waiting upstream |
| rsp_ready | input | 1 | Upstream takes the read byte |
| rsp_data | output | 8 | Read byte |
| trig_hit | input | 1 | Trigger event pulse from trigger logic |
| acq_run | output | 1 | Acquisition running |
| readback_en | output | 1 | Memory readback enabled |
| ext_we | output | 1 | Write strobe to external registers |
| ext_addr | output | 8 | Current register address |
| ext_wdata | output | 8 | Write byte for external registers |
| ext_rdata | input | 8 | Read byte from external register at `ext_addr` |

## Verification
A write, an address-nibble load and a mode change all take effect on the edge that accepts the command. The bench therefore checks `ext_addr`, `acq_run` and `readback_en` at the falling edge that follows the accepting edge. A read byte appears right after the accepting edge and is taken on the first later edge where `rsp_ready` is high. The response monitor samples a quarter period after each falling edge and pops one expected byte for every cycle in which both `rsp_valid` and `rsp_ready` are high. The external-write logger samples at the same offset, when `ext_we` is stable in the cycle that holds the command.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

  localparam int NIB_W      = 4;
  localparam int ADDR_LANES = 2;
  localparam int DATA_W     = 2 * NIB_W;
  localparam int ADDR_W     = NIB_W * ADDR_LANES;

  // address lane i is loaded by opcode OP_ADDR_LO + i
  localparam logic [NIB_W-1:0] OP_ADDR_LO  = 4'h0;
  localparam logic [NIB_W-1:0] OP_DATA_LO  = 4'h2;
  localparam logic [NIB_W-1:0] OP_DATA_WR  = 4'h3;
  localparam logic [NIB_W-1:0] OP_READ     = 4'h4;
  localparam logic [NIB_W-1:0] OP_READ_INC = 4'h5;

  typedef struct packed {
    logic [ADDR_LANES-1:0] lane_ld;
    logic                  stage;
    logic                  commit;
    logic                  rd;
    logic                  inc;
  } nrd_cmd_t;

endpackage

// File: rtl/nrd_cmd_decode.sv
module nrd_cmd_decode
  import nrd_pkg::*;
(
  input  logic                fire,
  input  logic [DATA_W-1:0]   cmd_byte,
  output nrd_cmd_t            cmd,
  output logic [NIB_W-1:0]    payload
);

  logic [NIB_W-1:0] op;

  assign op      = cmd_byte[DATA_W-1:NIB_W];
  assign payload = cmd_byte[NIB_W-1:0];

  always_comb begin
    cmd = '0;
    for (int i = 0; i < ADDR_LANES; i++) begin
      cmd.lane_ld[i] = fire && (op == OP_ADDR_LO + NIB_W'(i));
    end
    if (fire) begin
      case (op)
        OP_DATA_LO:  cmd.stage  = 1'b1;
        OP_DATA_WR:  cmd.commit = 1'b1;
        OP_READ:     cmd.rd     = 1'b1;
        OP_READ_INC: begin
          cmd.rd  = 1'b1;
          cmd.inc = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nrd_addr_ctl.sv
module nrd_addr_ctl
  import nrd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  nrd_cmd_t           cmd,
  input  logic [NIB_W-1:0]   payload,
  output logic [ADDR_W-1:0]  addr,
  output logic [NIB_W-1:0]   staged
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_ld;
  logic [NIB_W-1:0]  stage_q;

  // each address lane takes the payload when its opcode arrives
  for (genvar g = 0; g < ADDR_LANES; g++) begin : g_lane
    assign addr_ld[g*NIB_W +: NIB_W] = cmd.lane_ld[g] ? payload
                                                      : addr_q[g*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      stage_q <= '0;
    end else begin
      if (cmd.inc) begin
        addr_q <= addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
      end else begin
        addr_q <= addr_ld;
      end
      if (cmd.stage) begin
        stage_q <= payload;
      end
    end
  end

  assign addr   = addr_q;
  assign staged = stage_q;

endmodule

// File: rtl/nrd_regbank.sv
module nrd_regbank #(
  parameter int             DW            = 8,
  parameter int             AW            = 8,
  parameter logic [DW-1:0]  ID_VALUE      = 8'hA6,
  parameter logic [AW-1:0]  ADDR_ID       = 8'h00,
  parameter logic [AW-1:0]  ADDR_SCRATCH  = 8'h01,
  parameter logic [AW-1:0]  ADDR_MODE     = 8'h02,
  parameter logic [DW-1:0]  MODE_START    = 8'h0D,
  parameter logic [DW-1:0]  MODE_STOP     = 8'h11,
  parameter logic [DW-1:0]  MODE_READBACK = 8'h02,
  parameter int             TRIG_BIT      = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic           trig_hit,
  input  logic [DW-1:0]  ext_rdata,
  output logic [DW-1:0]  rdata,
  output logic           ext_we,
  output logic           acq_run,
  output logic           readback_en
);

  logic          sel_id, sel_scr, sel_mode, sel_ext;
  logic [DW-1:0] scratch_q;
  logic          run_q, rb_q, flag_q;
  logic [DW-1:0] status;

  assign sel_id   = (addr == ADDR_ID);
  assign sel_scr  = (addr == ADDR_SCRATCH);
  assign sel_mode = (addr == ADDR_MODE);
  assign sel_ext  = !(sel_id || sel_scr || sel_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q <= '0;
    end else if (wr_en && sel_scr) begin
      scratch_q <= wdata;
    end
  end

  // a start write outranks a trigger pulse in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rb_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (run_q && trig_hit) begin
        flag_q <= 1'b1;
      end
      if (wr_en && sel_mode) begin
        if (wdata == MODE_START) begin
          run_q  <= 1'b1;
          rb_q   <= 1'b0;
          flag_q <= 1'b0;
        end else if (wdata == MODE_STOP) begin
          run_q  <= 1'b0;
        end else if (wdata == MODE_READBACK) begin
          run_q  <= 1'b0;
          rb_q   <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    status           = '0;
    status[0]        = run_q;
    status[1]        = rb_q;
    status[TRIG_BIT] = flag_q;
    if (sel_id) begin
      rdata = ID_VALUE;
    end else if (sel_scr) begin
      rdata = scratch_q;
    end else if (sel_mode) begin
      rdata = status;
    end else begin
      rdata = ext_rdata;
    end
  end

  assign ext_we      = wr_en && sel_ext;
  assign acq_run     = run_q;
  assign readback_en = rb_q;

endmodule

// File: rtl/nrd_rsp_stage.sv
module nrd_rsp_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  logic          valid_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= din;
    end else if (valid_q && rsp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_data  = data_q;

endmodule

// File: rtl/nib_reg_decoder.sv
module nib_reg_decoder
  import nrd_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE      = 8'hA6,
  parameter logic [ADDR_W-1:0] ADDR_ID       = 8'h00,
  parameter logic [ADDR_W-1:0] ADDR_SCRATCH  = 8'h01,
  parameter logic [ADDR_W-1:0] ADDR_MODE     = 8'h02,
  parameter logic [DATA_W-1:0] MODE_START    = 8'h0D,
  parameter logic [DATA_W-1:0] MODE_STOP     = 8'h11,
  parameter logic [DATA_W-1:0] MODE_READBACK = 8'h02,
  parameter int                TRIG_BIT      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_byte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  input  logic              trig_hit,
  output logic              acq_run,
  output logic              readback_en,
  output logic              ext_we,
  output logic [7:0]        ext_addr,
  output logic [7:0]        ext_wdata,
  input  logic [7:0]        ext_rdata
);

  logic               fire;
  nrd_cmd_t           cmd;
  logic [NIB_W-1:0]   payload;
  logic [ADDR_W-1:0]  addr;
  logic [NIB_W-1:0]   staged;
  logic [DATA_W-1:0]  wdata;
  logic [DATA_W-1:0]  rdata;
  logic               busy;

  assign busy      = rsp_valid;
  assign cmd_ready = !busy;
  assign fire      = cmd_valid && cmd_ready;
  assign wdata     = {payload, staged};

  nrd_cmd_decode u_dec (
    .fire     (fire),
    .cmd_byte (cmd_byte),
    .cmd      (cmd),
    .payload  (payload)
  );

  nrd_addr_ctl u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .payload (payload),
    .addr    (addr),
    .staged  (staged)
  );

  nrd_regbank #(
    .DW            (DATA_W),
    .AW            (ADDR_W),
    .ID_VALUE      (ID_VALUE),
    .ADDR_ID       (ADDR_ID),
    .ADDR_SCRATCH  (ADDR_SCRATCH),
    .ADDR_MODE     (ADDR_MODE),
    .MODE_START    (MODE_START),
    .MODE_STOP     (MODE_STOP),
    .MODE_READBACK (MODE_READBACK),
    .TRIG_BIT      (TRIG_BIT)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cmd.commit),
    .addr        (addr),
    .wdata       (wdata),
    .trig_hit    (trig_hit),
    .ext_rdata   (ext_rdata),
    .rdata       (rdata),
    .ext_we      (ext_we),
    .acq_run     (acq_run),
    .readback_en (readback_en)
  );

  nrd_rsp_stage #(.DW(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd.rd),
    .din       (rdata),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign ext_addr  = addr;
  assign ext_wdata = wdata;

endmodule

// File: rtl/nrd_checker.sv
module nrd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_byte,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       ext_we,
  input logic [7:0] ext_addr
);

  logic       fire;
  logic [3:0] op;
  assign fire = cmd_valid && cmd_ready;
  assign op   = cmd_byte[7:4];

  // R12
  stall_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  // R12
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R5
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op == 4'h4 || op == 4'h5)) |=> rsp_valid);

  // R6
  read_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == 4'h5) |=> (ext_addr == $past(ext_addr) + 8'd1));

  // R4
  write_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == 4'h3) |=> $stable(ext_addr));

  // R11
  bad_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op > 4'h5) |=> ($stable(ext_addr) && !rsp_valid));

  // R13
  ext_we_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> (fire && op == 4'h3));

endmodule

bind nib_reg_decoder nrd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_byte  (cmd_byte),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .ext_we    (ext_we),
  .ext_addr  (ext_addr)
);

// File: tb/sim_nib_reg_decoder.sv
`timescale 1ns/1ps
module sim_nib_reg_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_byte = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       trig_hit = 1'b0;
  logic       acq_run, readback_en, ext_we;
  logic [7:0] ext_addr, ext_wdata, ext_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [15:0] wlog[$];

  always #10 clk = ~clk;

  assign ext_rdata = ext_addr ^ 8'h3C;

  nib_reg_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .trig_hit(trig_hit), .acq_run(acq_run),
    .readback_en(readback_en), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // response monitor: scoreboard pop on each upstream transfer
  always begin
    @(negedge clk);
    #5;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected response", {24'h0, rsp_data}, 32'hFFFF);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_data === e, t, {24'h0, rsp_data}, {24'h0, e});
      end
    end
  end

  // external write logger
  always begin
    @(negedge clk);
    #5;
    if (rst_n && ext_we) wlog.push_back({ext_addr, ext_wdata});
  end

  // callers are at a falling edge
  task automatic send(input logic [7:0] b);
    cmd_byte  = b;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic wr(input logic [7:0] d);
    send({4'h2, d[3:0]});
    send({4'h3, d[7:4]});
  endtask

  task automatic rd(input logic [7:0] e, input string t, input bit inc);
    exp_q.push_back(e);
    tag_q.push_back(t);
    send(inc ? 8'h50 : 8'h40);
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R5 responses outstanding", exp_q.size(), 0);
  endtask

  task automatic pulse_hit();
    trig_hit = 1'b1;
    @(negedge clk);
    trig_hit = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(acq_run == 1'b0 && readback_en == 1'b0, "R1 mode outputs",
        {acq_run, readback_en}, 0);
    chk(ext_addr == 8'h00, "R1 address", ext_addr, 0);
    rd(8'hA6, "R1 R7 id at reset address", 0);
    drain();
    set_addr(8'h02);
    rd(8'h00, "R1 mode after reset", 0);

    // R7 id write ignored
    set_addr(8'h00);
    wr(8'h12);
    rd(8'hA6, "R7 id after write", 0);
    chk(wlog.size() == 0, "R7 no external write", wlog.size(), 0);

    // R8 scratch
    set_addr(8'h01);
    wr(8'h55);
    rd(8'h55, "R8 scratch 55", 0);
    wr(8'hAA);
    rd(8'hAA, "R8 scratch AA", 0);

    // R3 staging and commit
    send(8'h27);
    rd(8'hAA, "R3 stage alone no write", 0);
    send(8'h3B);
    rd(8'hB7, "R3 commit B7", 0);
    send(8'h32);
    rd(8'h27, "R3 staged nibble kept", 0);

    // R2 address nibbles
    set_addr(8'h35);
    chk(ext_addr == 8'h35, "R2 both nibbles", ext_addr, 8'h35);
    send(8'h1C);
    chk(ext_addr == 8'hC5, "R2 high only", ext_addr, 8'hC5);
    send(8'h09);
    chk(ext_addr == 8'hC9, "R2 low only", ext_addr, 8'hC9);

    // R4 R13 burst write to external register
    set_addr(8'h40);
    drain();
    wlog.delete();
    wr(8'h11);
    wr(8'h22);
    wr(8'h33);
    chk(wlog.size() == 3, "R4 burst count", wlog.size(), 3);
    if (wlog.size() == 3) begin
      chk(wlog[0] == 16'h4011, "R13 ext write 0", wlog[0], 16'h4011);
      chk(wlog[1] == 16'h4022, "R4 ext write 1", wlog[1], 16'h4022);
      chk(wlog[2] == 16'h4033, "R4 ext write 2", wlog[2], 16'h4033);
    end
    chk(ext_addr == 8'h40, "R4 address kept", ext_addr, 8'h40);
    rd(8'h7C, "R13 external read", 0);

    // R6 read with increment
    set_addr(8'h00);
    rd(8'hA6, "R6 inc read 0", 1);
    rd(8'h27, "R6 inc read 1", 1);
    rd(8'h00, "R6 inc read 2", 1);
    drain();
    chk(ext_addr == 8'h03, "R6 address advanced", ext_addr, 8'h03);
    set_addr(8'hFF);
    rd(8'hC3, "R6 read at FF", 1);
    drain();
    chk(ext_addr == 8'h00, "R6 wrap", ext_addr, 0);

    // R5 plain read keeps address
    set_addr(8'h01);
    rd(8'h27, "R5 read a", 0);
    rd(8'h27, "R5 read b", 0);
    drain();
    chk(ext_addr == 8'h01, "R5 address kept", ext_addr, 8'h01);

    // R9 mode register
    set_addr(8'h02);
    wr(8'h0D);
    chk(acq_run == 1'b1 && readback_en == 1'b0, "R9 start outputs",
        {acq_run, readback_en}, 2'b10);
    rd(8'h01, "R9 status running", 0);
    wr(8'h02);
    chk(acq_run == 1'b0 && readback_en == 1'b1, "R9 readback outputs",
        {acq_run, readback_en}, 2'b01);
    rd(8'h02, "R9 status readback", 0);
    wr(8'h33);
    rd(8'h02, "R9 other value ignored", 0);
    wr(8'h0D);
    rd(8'h01, "R9 start clears readback", 0);
    wr(8'h11);
    chk(acq_run == 1'b0, "R9 stop output", acq_run, 0);
    rd(8'h00, "R9 status stopped", 0);

    // R10 trigger flag
    wr(8'h0D);
    pulse_hit();
    rd(8'h21, "R10 flag while running", 0);
    wr(8'h11);
    rd(8'h20, "R10 flag survives stop", 0);
    wr(8'h0D);
    rd(8'h01, "R10 start clears flag", 0);
    wr(8'h11);
    pulse_hit();
    rd(8'h00, "R10 hit ignored when stopped", 0);

    // R11 undefined opcodes
    set_addr(8'h01);
    drain();
    wlog.delete();
    send(8'h6A);
    send(8'h9F);
    send(8'hF0);
    chk(ext_addr == 8'h01, "R11 address unchanged", ext_addr, 8'h01);
    chk(rsp_valid == 1'b0, "R11 no response", rsp_valid, 0);
    chk(wlog.size() == 0, "R11 no write", wlog.size(), 0);
    send(8'h3C);
    rd(8'hC1, "R11 staged nibble unchanged", 0);
    rd(8'hC1, "R11 scratch", 0);

    // R12 back-pressure
    drain();
    rsp_ready = 1'b0;
    rd(8'hC1, "R12 held byte", 0);
    for (int i = 0; i < 3; i++) begin
      chk(rsp_valid == 1'b1, "R12 valid held", rsp_valid, 1);
      chk(cmd_ready == 1'b0, "R12 intake stalled", cmd_ready, 0);
      chk(rsp_data == 8'hC1, "R12 data stable", rsp_data, 8'hC1);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    drain();
    chk(cmd_ready == 1'b1, "R12 intake resumes", cmd_ready, 1);

    summary();
  end

endmodule